// File: doc/BRIEF.md
# SDRAM Access Sequencer with Auto-Precharge

This block turns single host requests into timed SDRAM command sequences. Once the memory is initialised, it takes one request at a time: a read, a write or a refresh. An access opens a row, issues a column command with auto-precharge, and then counts out CAS latency and burst beats. A write also waits for the write-recovery-plus-precharge time before the sequencer can open another row. A refresh issues one auto-refresh command and then waits out the refresh cycle time.

All wait counts come from nanosecond parameters and the clock period. The tRCD and tRFC waits are at least one clock. The post-write wait is the write-to-activate time in clocks minus three. Those three cycles are covered by the idle, activate and tRCD states that must pass anyway before the next activate. The data bus registers and the refresh interval timer are outside this block. The block drives only the strobes that pace them.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, and in every cycle while `init_done` is low, `sd_cmd` is NOP (4'b0111) and `rd_valid`, `wr_ack` and `sd_dq_oe` are low. Requests made in that time are lost. Once `init_done` rises, it stays high.
- R2: A request strobe is sampled only in idle. The cycle after an accepted access, `sd_cmd` is ACTIVE (4'b0011). `sd_addr` then carries host address bits 22:11 (the row) and `sd_ba` carries bits 10:9 (the bank).
- R3: The column command comes 1 + tRCD clocks after ACTIVE. With the defaults this is 2 clocks (tRCD = 1). It is READ (4'b0101) or WRITE (4'b0100). `sd_addr` then holds host bits 8:0 on bits 8:0, bit 10 is high (auto-precharge), bits 11 and 9 are low, and `sd_ba` is the bank.
- R4: `rd_valid` is high for exactly BURST_LEN consecutive cycles. The first of them is CAS_LAT cycles after the READ cycle (defaults: 3 and 4).
- R5: `wr_ack` and `sd_dq_oe` are high together for exactly BURST_LEN cycles, starting the cycle after WRITE. `sd_dq_oe` is never high on a read.
- R6: With the request strobe held high, ACTIVE-to-ACTIVE spacing is 3 + tRCD + BURST_LEN + DAL_WAIT clocks for writes, where DAL_WAIT = max(0, floor((tCK+7+tRP)/tCK) − 3). For reads the spacing is 2 + tRCD + CAS_LAT + BURST_LEN clocks. The defaults give 8 and 10.
- R7: A refresh issues AUTO_REFRESH (4'b0001) for one cycle, the cycle after it is accepted. It is followed by tRFC = floor(66/12) = 5 NOP clocks. With `ref_req` held high, refresh commands are 7 clocks apart.
- R8: When `ref_req` and `host_req` are both high in idle, the refresh runs and the access request is dropped.
- R9: Requests seen while a sequence is running are ignored. Each access issues exactly two non-NOP commands and each refresh exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Memory initialisation complete |
| host_req | input | 1 | Access request strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| ref_req | input | 1 | Refresh request strobe |
| host_addr | input | 23 | Linear address {row, bank, column} |
| sd_cmd | output | 4 | {CSn, RASn, CASn, WEn} |
| sd_addr | output | 12 | SDRAM address bus |
| sd_ba | output | 2 | SDRAM bank address |
| sd_dq_oe | output | 1 | Data bus output enable for write beats |
| wr_ack | output | 1 | Write beat accepted; next beat requested |
| rd_valid | output | 1 | Read beat valid on the data bus |

## Verification
The embedded properties check, on every cycle, the relations that hold locally:
- NOP before initialisation.
- A NOP after each ACTIVE and each AUTO_REFRESH.
- The auto-precharge bit on every column command.
- Write-acknowledge and output-enable moving together.
- No output enable while read data is valid.

Spacing, beat counts, latency alignment, address splitting, refresh priority and the dropping of requests while busy span many cycles. Only the bench's timed scenarios show them, by recording each sequence and back-to-back runs with the strobe held.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int CAS_LAT    = 3,
  parameter int BURST_LEN  = 4,
  parameter int TCK_NS     = 12,
  parameter int TRCD_NS    = 15,
  parameter int TRP_NS     = 15,
  parameter int TRFC_NS    = 66,
  parameter int TWR_ADD_NS = 7,
  parameter int ROW_W      = 12,
  parameter int BANK_W     = 2,
  parameter int COL_W      = 9,
  localparam int ADDR_W    = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic              ref_req,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [3:0]        sd_cmd,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              sd_dq_oe,
  output logic              wr_ack,
  output logic              rd_valid
);
  localparam int RCD_CLK  = (TRCD_NS / TCK_NS < 1) ? 1 : TRCD_NS / TCK_NS;
  localparam int RFC_CLK  = (TRFC_NS / TCK_NS < 1) ? 1 : TRFC_NS / TCK_NS;
  localparam int DAL_CLK  = (TCK_NS + TWR_ADD_NS + TRP_NS) / TCK_NS;
  localparam int DAL_WAIT = (DAL_CLK < 3) ? 0 : DAL_CLK - 3;
  localparam int CMAX     = (RFC_CLK > BURST_LEN) ? RFC_CLK : BURST_LEN;
  localparam int CMAX2    = (CMAX > DAL_WAIT + RCD_CLK + CAS_LAT) ? CMAX : DAL_WAIT + RCD_CLK + CAS_LAT;
  localparam int CNT_W    = $clog2(CMAX2 + 1);
  localparam int AP_BIT   = 10;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR  = 4'b0100, C_REF = 4'b0001;

  typedef enum logic [3:0] {
    S_IDLE = 4'b0000, S_RCD  = 4'b0001, S_CL   = 4'b0010, S_RDAT = 4'b0011,
    S_WDAT = 4'b0100, S_RFC  = 4'b0101, S_DAL  = 4'b0110, S_ACT  = 4'b1000,
    S_RDA  = 4'b1001, S_WRA  = 4'b1010, S_REF  = 4'b1011
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic              last;
  logic [ROW_W-1:0]  col_word;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      if (!last) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE:
          if (init_done && ref_req) st <= S_REF;
          else if (init_done && host_req) begin
            st     <= S_ACT;
            addr_q <= host_addr;
            wr_q   <= host_wr;
          end
        S_ACT: begin st <= S_RCD; cnt <= CNT_W'(RCD_CLK - 1); end
        S_RCD: if (last) st <= wr_q ? S_WRA : S_RDA;
        S_RDA: begin st <= S_CL; cnt <= CNT_W'(CAS_LAT - 2); end
        S_CL:  if (last) begin st <= S_RDAT; cnt <= CNT_W'(BURST_LEN - 1); end
        S_RDAT: if (last) st <= S_IDLE;
        S_WRA: begin st <= S_WDAT; cnt <= CNT_W'(BURST_LEN - 1); end
        S_WDAT:
          if (last) begin
            if (DAL_WAIT > 0) begin st <= S_DAL; cnt <= CNT_W'(DAL_WAIT - 1); end
            else st <= S_IDLE;
          end
        S_DAL: if (last) st <= S_IDLE;
        S_REF: begin st <= S_RFC; cnt <= CNT_W'(RFC_CLK - 1); end
        S_RFC: if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    col_word = '0;
    col_word[COL_W-1:0] = addr_q[COL_W-1:0];
    col_word[AP_BIT] = 1'b1;
  end

  always_comb begin
    sd_cmd  = C_NOP;
    sd_addr = '0;
    case (st)
      S_ACT: begin sd_cmd = C_ACT; sd_addr = addr_q[ADDR_W-1 -: ROW_W]; end
      S_RDA: begin sd_cmd = C_RD;  sd_addr = col_word; end
      S_WRA: begin sd_cmd = C_WR;  sd_addr = col_word; end
      S_REF: sd_cmd = C_REF;
      default: ;
    endcase
  end

  assign sd_ba    = addr_q[COL_W +: BANK_W];
  assign wr_ack   = (st == S_WDAT);
  assign sd_dq_oe = (st == S_WDAT);
  assign rd_valid = (st == S_RDAT);

  // R1
  nop_before_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> sd_cmd == C_NOP);
  // R2
  act_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd == C_ACT |=> sd_cmd == C_NOP);
  // R3
  auto_pre_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_RD || sd_cmd == C_WR) |-> sd_addr[AP_BIT]);
  // R5
  ack_oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack == sd_dq_oe);
  // R5
  no_oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sd_dq_oe);
  // R7
  ref_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd == C_REF |=> sd_cmd == C_NOP);
endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;
  localparam int RCD = 1, CL = 3, BL = 4, RFC = 5, DALW = 0;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                         WR = 4'b0100, REF = 4'b0001;
  localparam int WIN = 16;
  // {kind[1:0], addr[22:0]}: kind 0 read, 1 write, 2 refresh, 3 refresh+access
  localparam logic [24:0] VEC [6] = '{
    {2'd0, 12'hABC, 2'd1, 9'h155},
    {2'd1, 12'h123, 2'd2, 9'h0AA},
    {2'd0, 12'hFFF, 2'd3, 9'h1FF},
    {2'd1, 12'h000, 2'd0, 9'h000},
    {2'd2, 12'h555, 2'd1, 9'h001},
    {2'd3, 12'h777, 2'd2, 9'h100}
  };

  logic clk = 0, rst_n = 0, init_done = 0, host_req = 0, host_wr = 0, ref_req = 0;
  logic [22:0] host_addr = '0;
  logic [3:0] sd_cmd;
  logic [11:0] sd_addr;
  logic [1:0] sd_ba;
  logic sd_dq_oe, wr_ack, rd_valid;

  int n_chk = 0, n_fail = 0;
  int t_act, t_act2, t_col, t_ar, t_ar2, n_cmd, rd_first, rd_n, wr_first, wr_n, oe_n;
  logic [3:0] col_cmd;
  logic [11:0] act_addr, col_addr;
  logic [1:0] act_ba, col_ba;

  always #4 clk = ~clk;

  sdram_cmd_seq dut_i (.clk(clk), .rst_n(rst_n), .init_done(init_done), .host_req(host_req),
    .host_wr(host_wr), .ref_req(ref_req), .host_addr(host_addr), .sd_cmd(sd_cmd),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq_oe(sd_dq_oe), .wr_ack(wr_ack), .rd_valid(rd_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit acc, input bit wr, input bit rf, input logic [22:0] a, input bit hold);
    t_act = 0; t_act2 = 0; t_col = 0; t_ar = 0; t_ar2 = 0; n_cmd = 0;
    rd_first = 0; rd_n = 0; wr_first = 0; wr_n = 0; oe_n = 0;
    col_cmd = NOP; act_addr = '0; col_addr = '0; act_ba = '0; col_ba = '0;
    host_req = acc; host_wr = wr; ref_req = rf; host_addr = a;
    @(negedge clk);
    if (!hold) begin host_req = 0; ref_req = 0; end
    for (int i = 1; i <= WIN; i++) begin
      if (sd_cmd != NOP) n_cmd++;
      if (sd_cmd == ACT) begin
        if (t_act == 0) begin t_act = i; act_addr = sd_addr; act_ba = sd_ba; end
        else if (t_act2 == 0) t_act2 = i;
      end
      if ((sd_cmd == RD || sd_cmd == WR) && t_col == 0) begin
        t_col = i; col_cmd = sd_cmd; col_addr = sd_addr; col_ba = sd_ba;
      end
      if (sd_cmd == REF) begin
        if (t_ar == 0) t_ar = i; else if (t_ar2 == 0) t_ar2 = i;
      end
      if (rd_valid) begin if (rd_n == 0) rd_first = i; rd_n++; end
      if (wr_ack) begin if (wr_n == 0) wr_first = i; wr_n++; end
      if (sd_dq_oe) oe_n++;
      @(negedge clk);
    end
    host_req = 0; ref_req = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sd_cmd == NOP && !rd_valid && !wr_ack && !sd_dq_oe, "R1 reset", sd_cmd, NOP);
    rst_n = 1;
    @(negedge clk);
    run(1, 0, 1, 23'h1234, 0);
    chk(n_cmd == 0, "R1 no command before init_done", n_cmd, 0);
    chk(rd_n + wr_n + oe_n == 0, "R1 strobes low before init_done", rd_n + wr_n + oe_n, 0);
    init_done = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] k;
      logic [22:0] a;
      logic [11:0] cw;
      k = VEC[v][24:23]; a = VEC[v][22:0];
      cw = {3'b010, a[8:0]};
      if (k < 2) begin
        run(1, k[0], 0, a, 0);
        chk(t_act == 1, "R2 ACTIVE timing", t_act, 1);
        chk(act_addr == a[22:11], "R2 row address", act_addr, a[22:11]);
        chk(act_ba == a[10:9], "R2 bank at ACTIVE", act_ba, a[10:9]);
        chk(t_col == 2 + RCD, "R3 column command timing", t_col, 2 + RCD);
        chk(col_cmd == (k[0] ? WR : RD), "R3 column command code", col_cmd, k[0] ? WR : RD);
        chk(col_addr == cw, "R3 column address with auto-precharge", col_addr, cw);
        chk(col_ba == a[10:9], "R3 bank at column command", col_ba, a[10:9]);
        chk(n_cmd == 2, "R9 commands per access", n_cmd, 2);
        if (k[0]) begin
          chk(wr_first == t_col + 1, "R5 first write beat", wr_first, t_col + 1);
          chk(wr_n == BL, "R5 write beats", wr_n, BL);
          chk(oe_n == BL, "R5 output enable beats", oe_n, BL);
          chk(rd_n == 0, "R4 no read valid on write", rd_n, 0);
        end else begin
          chk(rd_first == t_col + CL, "R4 read latency", rd_first, t_col + CL);
          chk(rd_n == BL, "R4 read beats", rd_n, BL);
          chk(oe_n == 0, "R5 no output enable on read", oe_n, 0);
        end
      end else begin
        run(k == 3, 0, 1, a, 0);
        chk(t_ar == 1, "R7 refresh timing", t_ar, 1);
        chk(n_cmd == 1, "R7 single refresh command", n_cmd, 1);
        if (k == 3) chk(t_act == 0, "R8 access dropped under refresh", t_act, 0);
      end
    end

    run(1, 0, 0, 23'h2A5A5, 1);
    chk(t_act2 - t_act == 2 + RCD + CL + BL, "R6 read ACTIVE spacing", t_act2 - t_act, 2 + RCD + CL + BL);
    chk(n_cmd == 4, "R9 held request ignored while busy (read)", n_cmd, 4);
    run(1, 1, 0, 23'h15A5A, 1);
    chk(t_act2 - t_act == 3 + RCD + BL + DALW, "R6 write ACTIVE spacing", t_act2 - t_act, 3 + RCD + BL + DALW);
    chk(n_cmd == 4, "R9 held request ignored while busy (write)", n_cmd, 4);
    run(0, 0, 1, 23'h0, 1);
    chk(t_ar2 - t_ar == RFC + 2, "R7 refresh spacing", t_ar2 - t_ar, RFC + 2);
    chk(n_cmd == 3, "R7 refresh count in window", n_cmd, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule